// File: doc/BRIEF.md
# Post-Update Load/Store Execution Unit

This block is the execution stage for 64-bit integer loads and stores that update their base register. It accepts one decoded operation per handshake. The operation gives the access size, load or store, zero or sign extension, immediate or indexed offset, and post- or pre-update addressing. It also carries the base, index and store-data operand values, the base and target register indices, and a 16-bit immediate. The unit issues one memory request over a valid/ready handshake and waits for the response. It then writes the load result and the new base value on two register write ports.

In post-update mode the memory is accessed at the unmodified base value. The base register is advanced by the offset only after the access completes. Pre-update mode is also supported. In that mode the sum of base and offset is both the address and the value written back. The memory word is 64 bits wide and big-endian: address offset 0 is the most significant byte lane. Byte enables and store data are placed by the low address bits and the access size. Loads with an invalid register combination are rejected without touching memory or registers.

Top module: `pu_lsu`

## Requirements
- R1: In post-update mode (op_post_i=1) mem_addr_o equals the ra_i value captured at acceptance. The offset takes no part in the address.
- R2: After the access, ra_data_o equals RA plus the offset. In immediate form (op_indexed_i=0) the offset is the sign-extended 16-bit imm_i. In indexed form (op_indexed_i=1) the offset is rb_i. ra_idx_o carries the accepted RA index.
- R3: For a doubleword (op_size_i=3) in immediate form, the offset is imm_i[15:2] followed by two zero bits, sign-extended. The two low immediate bits are ignored.
- R4: A zero-extending load (op_sext_i=0) returns the 1-, 2-, 4- or 8-byte datum (op_size_i = 0, 1, 2, 3) in the low bits of rt_data_o, with all upper bits zero.
- R5: A sign-extending load of halfword or word size (op_sext_i=1) sign-extends the datum to 64 bits.
- R6: Byte lane k (address offset k, 0..7) is mem_wdata_o[63-8k:56-8k] and is enabled by mem_be_o[k]. For an aligned access, the enables cover the lanes offset to offset+size-1. A store drives mem_we_o=1 and places the low 1, 2, 4 or 8 bytes of rs_i in those lanes, most significant byte at the lowest address, with the other lanes zero. A store writes only the RA port (rt_we_o stays 0).
- R7: A load whose RA index is 0, or whose RA index equals its RT index, is invalid. illegal_o pulses for the one cycle after acceptance. No memory request and no register write occur.
- R8: In pre-update mode (op_post_i=0) mem_addr_o and ra_data_o both equal RA plus the offset.
- R9: The request stays asserted, with stable address, enables and data, until mem_req_ready_i. ra_we_o (and rt_we_o for loads) assert together for exactly one cycle, in the cycle after the one in which mem_rsp_valid_i is sampled high.
- R10: op_ready_o is high only when no operation is in flight, so one operation is handled at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation valid |
| op_ready_o | output | 1 | Unit can accept an operation |
| op_size_i | input | 2 | Access size: 0=byte,1=half,2=word,3=double |
| op_store_i | input | 1 | 1=store, 0=load |
| op_sext_i | input | 1 | Load sign-extension select |
| op_indexed_i | input | 1 | 1=offset from rb_i, 0=from imm_i |
| op_post_i | input | 1 | 1=post-update, 0=pre-update |
| ra_i | input | 64 | Base register value |
| rb_i | input | 64 | Index register value |
| rs_i | input | 64 | Store data register value |
| ra_idx_i | input | 5 | Base register index |
| rt_idx_i | input | 5 | Load target register index |
| imm_i | input | 16 | Immediate offset field |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_addr_o | output | 64 | Memory byte address |
| mem_we_o | output | 1 | Write request |
| mem_be_o | output | 8 | Byte lane enables |
| mem_wdata_o | output | 64 | Write data, big-endian lanes |
| mem_rsp_valid_i | input | 1 | Read data or write acknowledge |
| mem_rdata_i | input | 64 | Read data, big-endian lanes |
| rt_we_o | output | 1 | Load result write enable |
| rt_idx_o | output | 5 | Load result register index |
| rt_data_o | output | 64 | Load result |
| ra_we_o | output | 1 | Base update write enable |
| ra_idx_o | output | 5 | Base update register index |
| ra_data_o | output | 64 | Updated base value |
| illegal_o | output | 1 | Invalid form detected |

## Verification
The hardest situation to reach is a request held under back-pressure while lane placement must stay exact. This happens with sub-word accesses at non-zero offsets and with negative offsets that move the base downwards. The bench stalls mem_req_ready_i for several cycles on chosen operations and checks that the request stays stable. It uses base values whose low bits select inner byte lanes and fills the unused read lanes with nonzero data, so any masking or shift error shows up in rt_data_o. Doubleword immediates with nonzero low bits, positive and negative, check the offset truncation. Both invalid-form causes are followed directly by legal operations to check that the unit recovers.

// File: rtl/pu_lsu_pkg.sv
`timescale 1ns/1ps
package pu_lsu_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WB,
    ST_ILL
  } lsu_state_e;
endpackage

// File: rtl/pu_lsu_agen.sv
`timescale 1ns/1ps
module pu_lsu_agen
  import pu_lsu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16,
  parameter int IDX_W = 5
) (
  input  acc_size_e        size_i,
  input  logic             store_i,
  input  logic             indexed_i,
  input  logic             post_i,
  input  logic [XLEN-1:0]  ra_i,
  input  logic [XLEN-1:0]  rb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  input  logic [IDX_W-1:0] rt_idx_i,
  output logic [XLEN-1:0]  addr_o,
  output logic [XLEN-1:0]  base_o,
  output logic             illegal_o
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [IMM_W-1:0] imm_eff;
  logic [XLEN-1:0]  offset;
  logic [XLEN-1:0]  sum;

  // doubleword immediates drop the two low field bits
  always_comb begin
    imm_eff = imm_i;
    if (size_i == SZ_D) imm_eff = {imm_i[IMM_W-1:2], 2'b00};
  end

  assign offset    = indexed_i ? rb_i : {{EXT_W{imm_eff[IMM_W-1]}}, imm_eff};
  assign sum       = ra_i + offset;
  assign addr_o    = post_i ? ra_i : sum;
  assign base_o    = sum;
  assign illegal_o = !store_i && ((ra_idx_i == '0) || (ra_idx_i == rt_idx_i));
endmodule

// File: rtl/pu_lsu_lane.sv
`timescale 1ns/1ps
module pu_lsu_lane
  import pu_lsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  acc_size_e              size_i,
  input  logic [$clog2(XLEN/8)-1:0] off_i,
  input  logic [XLEN-1:0]        rs_i,
  output logic [XLEN/8-1:0]      be_o,
  output logic [XLEN-1:0]        wdata_o
);
  localparam int NB    = XLEN / 8;
  localparam int OFF_W = $clog2(NB);

  logic [OFF_W:0] nb;
  logic [OFF_W:0] lo;
  logic [OFF_W:0] hi;

  assign nb = (OFF_W+1)'(1) << size_i;
  assign lo = {1'b0, off_i};
  assign hi = lo + nb;

  for (genvar k = 0; k < NB; k++) begin : g_lane
    localparam logic [OFF_W:0] KL = (OFF_W+1)'(k);
    logic [OFF_W-1:0] src;
    // datum byte nearest the MSB lands on the lowest address
    assign src = OFF_W'(nb - (OFF_W+1)'(1) - KL + lo);
    assign be_o[k] = (KL >= lo) && (KL < hi);
    assign wdata_o[XLEN-1-8*k -: 8] = be_o[k] ? rs_i[{src, 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/pu_lsu_extract.sv
`timescale 1ns/1ps
module pu_lsu_extract
  import pu_lsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  acc_size_e                 size_i,
  input  logic                      sext_i,
  input  logic [$clog2(XLEN/8)-1:0] off_i,
  input  logic [XLEN-1:0]           rdata_i,
  output logic [XLEN-1:0]           data_o
);
  localparam int NB    = XLEN / 8;
  localparam int OFF_W = $clog2(NB);

  logic [OFF_W:0]  nb;
  logic [OFF_W:0]  shamt;
  logic [XLEN-1:0] raw;

  assign nb    = (OFF_W+1)'(1) << size_i;
  assign shamt = (OFF_W+1)'(NB) - nb - {1'b0, off_i};
  assign raw   = rdata_i >> {shamt, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_B:    data_o = {{(XLEN-8){sext_i & raw[7]}}, raw[7:0]};
      SZ_H:    data_o = {{(XLEN-16){sext_i & raw[15]}}, raw[15:0]};
      SZ_W:    data_o = {{(XLEN-32){sext_i & raw[31]}}, raw[31:0]};
      default: data_o = raw;
    endcase
  end
endmodule

// File: rtl/pu_lsu.sv
`timescale 1ns/1ps
module pu_lsu
  import pu_lsu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  output logic             op_ready_o,
  input  logic [1:0]       op_size_i,
  input  logic             op_store_i,
  input  logic             op_sext_i,
  input  logic             op_indexed_i,
  input  logic             op_post_i,
  input  logic [XLEN-1:0]  ra_i,
  input  logic [XLEN-1:0]  rb_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  input  logic [IDX_W-1:0] rt_idx_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic             mem_we_o,
  output logic [XLEN/8-1:0] mem_be_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic             mem_rsp_valid_i,
  input  logic [XLEN-1:0]  mem_rdata_i,
  output logic             rt_we_o,
  output logic [IDX_W-1:0] rt_idx_o,
  output logic [XLEN-1:0]  rt_data_o,
  output logic             ra_we_o,
  output logic [IDX_W-1:0] ra_idx_o,
  output logic [XLEN-1:0]  ra_data_o,
  output logic             illegal_o
);
  localparam int NB    = XLEN / 8;
  localparam int OFF_W = $clog2(NB);

  acc_size_e  op_size;
  lsu_state_e state_q, state_d;

  logic [XLEN-1:0] ag_addr, ag_base, ln_wdata;
  logic [NB-1:0]   ln_be;
  logic            ag_illegal;
  logic            accept;

  logic [XLEN-1:0]  addr_q, base_q, wdata_q, rdata_q;
  logic [NB-1:0]    be_q;
  acc_size_e        size_q;
  logic             store_q, sext_q;
  logic [IDX_W-1:0] ra_idx_q, rt_idx_q;

  assign op_size = acc_size_e'(op_size_i);
  assign accept  = (state_q == ST_IDLE) && op_valid_i;

  pu_lsu_agen #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) agen_i (
    .size_i    (op_size),
    .store_i   (op_store_i),
    .indexed_i (op_indexed_i),
    .post_i    (op_post_i),
    .ra_i      (ra_i),
    .rb_i      (rb_i),
    .imm_i     (imm_i),
    .ra_idx_i  (ra_idx_i),
    .rt_idx_i  (rt_idx_i),
    .addr_o    (ag_addr),
    .base_o    (ag_base),
    .illegal_o (ag_illegal)
  );

  pu_lsu_lane #(.XLEN(XLEN)) lane_i (
    .size_i  (op_size),
    .off_i   (ag_addr[OFF_W-1:0]),
    .rs_i    (rs_i),
    .be_o    (ln_be),
    .wdata_o (ln_wdata)
  );

  pu_lsu_extract #(.XLEN(XLEN)) extract_i (
    .size_i  (size_q),
    .sext_i  (sext_q),
    .off_i   (addr_q[OFF_W-1:0]),
    .rdata_i (rdata_q),
    .data_o  (rt_data_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (op_valid_i) state_d = ag_illegal ? ST_ILL : ST_REQ;
      ST_REQ:  if (mem_req_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid_i) state_d = ST_WB;
      ST_WB:   state_d = ST_IDLE;
      ST_ILL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      base_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      be_q     <= '0;
      size_q   <= SZ_B;
      store_q  <= 1'b0;
      sext_q   <= 1'b0;
      ra_idx_q <= '0;
      rt_idx_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q   <= ag_addr;
        base_q   <= ag_base;
        wdata_q  <= op_store_i ? ln_wdata : '0;
        be_q     <= ln_be;
        size_q   <= op_size;
        store_q  <= op_store_i;
        sext_q   <= op_sext_i;
        ra_idx_q <= ra_idx_i;
        rt_idx_q <= rt_idx_i;
      end
      if ((state_q == ST_WAIT) && mem_rsp_valid_i) rdata_q <= mem_rdata_i;
    end
  end

  assign op_ready_o      = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_addr_o      = addr_q;
  assign mem_we_o        = store_q;
  assign mem_be_o        = be_q;
  assign mem_wdata_o     = wdata_q;
  assign ra_we_o         = (state_q == ST_WB);
  assign rt_we_o         = (state_q == ST_WB) && !store_q;
  assign ra_idx_o        = ra_idx_q;
  assign rt_idx_o        = rt_idx_q;
  assign ra_data_o       = base_q;
  assign illegal_o       = (state_q == ST_ILL);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_addr_o) && $stable(mem_be_o) && $stable(mem_wdata_o));

  // R9
  wb_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_we_o |-> $past(mem_rsp_valid_i));

  // R9
  wb_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_we_o |-> ra_we_o);

  // R7
  ill_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !mem_req_valid_o && !ra_we_o && !rt_we_o);

  // R7
  ill_zero_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_ready_o && !op_store_i && (ra_idx_i == '0) |=> illegal_o);

  // R1
  post_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_ready_o && op_post_i && op_store_i |=> mem_addr_o == $past(ra_i));

  // R10
  single_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o || ra_we_o || illegal_o) |-> !op_ready_o);

  // R6
  be_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && ((mem_addr_o[OFF_W-1:0] & ((OFF_W'(1) << size_q) - OFF_W'(1))) == '0)
      |-> $countones(mem_be_o) == (32'd1 << size_q));
endmodule

// File: tb/pu_lsu_tb_top.sv
`timescale 1ns/1ps
module pu_lsu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic        op_ready_o;
  logic [1:0]  op_size_i = '0;
  logic        op_store_i = 1'b0, op_sext_i = 1'b0, op_indexed_i = 1'b0, op_post_i = 1'b0;
  logic [63:0] ra_i = '0, rb_i = '0, rs_i = '0;
  logic [4:0]  ra_idx_i = '0, rt_idx_i = '0;
  logic [15:0] imm_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [63:0] mem_addr_o;
  logic        mem_we_o;
  logic [7:0]  mem_be_o;
  logic [63:0] mem_wdata_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        rt_we_o;
  logic [4:0]  rt_idx_o;
  logic [63:0] rt_data_o;
  logic        ra_we_o;
  logic [4:0]  ra_idx_o;
  logic [63:0] ra_data_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  pu_lsu dut_i (
    .clk_i, .rst_ni, .op_valid_i, .op_ready_o, .op_size_i, .op_store_i, .op_sext_i,
    .op_indexed_i, .op_post_i, .ra_i, .rb_i, .rs_i, .ra_idx_i, .rt_idx_i, .imm_i,
    .mem_req_valid_o, .mem_req_ready_i, .mem_addr_o, .mem_we_o, .mem_be_o, .mem_wdata_o,
    .mem_rsp_valid_i, .mem_rdata_i, .rt_we_o, .rt_idx_o, .rt_data_o, .ra_we_o, .ra_idx_o,
    .ra_data_o, .illegal_o
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_op(input logic [1:0] sz, input logic st, input logic sx,
                          input logic ix, input logic po, input logic [63:0] ra,
                          input logic [63:0] rb, input logic [63:0] rs,
                          input logic [4:0] rai, input logic [4:0] rti, input logic [15:0] imm);
    @(negedge clk_i);
    chk("R10 ready before issue", {63'b0, op_ready_o}, 64'd1);
    op_size_i = sz; op_store_i = st; op_sext_i = sx; op_indexed_i = ix; op_post_i = po;
    ra_i = ra; rb_i = rb; rs_i = rs; ra_idx_i = rai; rt_idx_i = rti; imm_i = imm;
    op_valid_i = 1'b1;
    @(negedge clk_i);
    op_valid_i = 1'b0;
  endtask

  task automatic run_op(input string tag, input logic [1:0] sz, input logic st, input logic sx,
                        input logic ix, input logic po, input logic [63:0] ra,
                        input logic [63:0] rb, input logic [63:0] rs, input logic [15:0] imm,
                        input int stall, input logic [63:0] rdata,
                        input logic [63:0] e_addr, input logic [7:0] e_be,
                        input logic [63:0] e_wd, input logic [63:0] e_rt,
                        input logic [63:0] e_ra);
    drive_op(sz, st, sx, ix, po, ra, rb, rs, 5'd4, 5'd5, imm);
    chk({tag, " R9 req valid"}, {63'b0, mem_req_valid_o}, 64'd1);
    chk({tag, " R10 busy"}, {63'b0, op_ready_o}, 64'd0);
    chk({tag, " addr"}, mem_addr_o, e_addr);
    chk({tag, " R6 be"}, {56'b0, mem_be_o}, {56'b0, e_be});
    chk({tag, " R6 we"}, {63'b0, mem_we_o}, {63'b0, st});
    if (st) chk({tag, " R6 wdata"}, mem_wdata_o, e_wd);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk_i);
      chk({tag, " R9 held valid"}, {63'b0, mem_req_valid_o}, 64'd1);
      chk({tag, " R9 held addr"}, mem_addr_o, e_addr);
    end
    mem_req_ready_i = 1'b1;
    @(negedge clk_i);
    mem_req_ready_i = 1'b0;
    chk({tag, " R9 req dropped"}, {63'b0, mem_req_valid_o}, 64'd0);
    chk({tag, " R9 no early wb"}, {63'b0, ra_we_o}, 64'd0);
    mem_rsp_valid_i = 1'b1;
    mem_rdata_i = rdata;
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0;
    mem_rdata_i = '0;
    chk({tag, " R9 ra_we"}, {63'b0, ra_we_o}, 64'd1);
    chk({tag, " R2 ra_idx"}, {59'b0, ra_idx_o}, 64'd4);
    chk({tag, " R2 ra_data"}, ra_data_o, e_ra);
    chk({tag, " R6 rt_we"}, {63'b0, rt_we_o}, {63'b0, !st});
    if (!st) begin
      chk({tag, " rt_idx"}, {59'b0, rt_idx_o}, 64'd5);
      chk({tag, " rt_data"}, rt_data_o, e_rt);
    end
    @(negedge clk_i);
    chk({tag, " R9 single wb"}, {63'b0, ra_we_o}, 64'd0);
    chk({tag, " R10 ready again"}, {63'b0, op_ready_o}, 64'd1);
  endtask

  task automatic run_illegal(input string tag, input logic [4:0] rai, input logic [4:0] rti);
    drive_op(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 64'h9000, 64'h0, 64'h0, rai, rti, 16'h0008);
    chk({tag, " R7 illegal pulse"}, {63'b0, illegal_o}, 64'd1);
    chk({tag, " R7 no req"}, {63'b0, mem_req_valid_o}, 64'd0);
    chk({tag, " R7 no ra write"}, {63'b0, ra_we_o}, 64'd0);
    chk({tag, " R7 no rt write"}, {63'b0, rt_we_o}, 64'd0);
    @(negedge clk_i);
    chk({tag, " R7 pulse ends"}, {63'b0, illegal_o}, 64'd0);
    chk({tag, " R7 still no req"}, {63'b0, mem_req_valid_o}, 64'd0);
    chk({tag, " R7 still no write"}, {62'b0, ra_we_o, rt_we_o}, 64'd0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // reset state
    chk("R10 reset ready", {63'b0, op_ready_o}, 64'd1);
    chk("R9 reset outputs", {60'b0, mem_req_valid_o, ra_we_o, rt_we_o, illegal_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R2 R4 byte load, negative immediate
    run_op("lbz post imm", 2'd0, 0, 0, 0, 1, 64'h1000, 64'h0, 64'h0, 16'hFFFC, 0,
           64'hA511_2233_4455_6677, 64'h1000, 8'h01, 64'h0, 64'hA5, 64'h0FFC);
    // R4 halfword at lanes 6..7, indexed
    run_op("lhz post idx", 2'd1, 0, 0, 1, 1, 64'h2006, 64'h10, 64'h0, 16'h0, 0,
           64'hFFEE_DDCC_BBAA_8123, 64'h2006, 8'hC0, 64'h0, 64'h8123, 64'h2016);
    // R5 halfword sign extension with stall
    run_op("lha post idx", 2'd1, 0, 1, 1, 1, 64'h2006, 64'h10, 64'h0, 16'h0, 2,
           64'hFFEE_DDCC_BBAA_8123, 64'h2006, 8'hC0, 64'h0, 64'hFFFF_FFFF_FFFF_8123, 64'h2016);
    // R5 word sign extension, negative index
    run_op("lwa post idx", 2'd2, 0, 1, 1, 1, 64'h3004, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 16'h0, 1,
           64'h1111_2222_8000_0001, 64'h3004, 8'hF0, 64'h0, 64'hFFFF_FFFF_8000_0001, 64'h2FFC);
    // R4 word zero extension, top bit set
    run_op("lwz post imm", 2'd2, 0, 0, 0, 1, 64'h40, 64'h0, 64'h0, 16'h0008, 0,
           64'hDEAD_BEEF_0000_FFFF, 64'h40, 8'h0F, 64'h0, 64'h0000_0000_DEAD_BEEF, 64'h48);
    // R3 doubleword immediate, low bits dropped, positive and negative
    run_op("ld R3 pos", 2'd3, 0, 0, 0, 1, 64'h100, 64'h0, 64'h0, 16'h0007, 0,
           64'h0123_4567_89AB_CDEF, 64'h100, 8'hFF, 64'h0, 64'h0123_4567_89AB_CDEF, 64'h104);
    run_op("ld R3 neg", 2'd3, 0, 0, 0, 1, 64'h200, 64'h0, 64'h0, 16'hFFF9, 0,
           64'h0123_4567_89AB_CDEF, 64'h200, 8'hFF, 64'h0, 64'h0123_4567_89AB_CDEF, 64'h1F8);
    // R6 stores at each size
    run_op("stb post imm", 2'd0, 1, 0, 0, 1, 64'h5003, 64'h0, 64'hAAAA_AAAA_AAAA_AA77, 16'h0001, 0,
           64'h0, 64'h5003, 8'h08, 64'h0000_0077_0000_0000, 64'h0, 64'h5004);
    run_op("sth post idx", 2'd1, 1, 0, 1, 1, 64'h6002, 64'h2, 64'h1234_5678_9ABC_DEF0, 16'h0, 0,
           64'h0, 64'h6002, 8'h0C, 64'h0000_DEF0_0000_0000, 64'h0, 64'h6004);
    run_op("stw post imm", 2'd2, 1, 0, 0, 1, 64'h7000, 64'h0, 64'h1234_5678_9ABC_DEF0, 16'h0010, 3,
           64'h0, 64'h7000, 8'h0F, 64'h9ABC_DEF0_0000_0000, 64'h0, 64'h7010);
    run_op("std post idx", 2'd3, 1, 0, 1, 1, 64'h8000, 64'h40, 64'h1234_5678_9ABC_DEF0, 16'h0, 1,
           64'h0, 64'h8000, 8'hFF, 64'h1234_5678_9ABC_DEF0, 64'h0, 64'h8040);
    // R8 pre-update contrast
    run_op("lbz R8 pre imm", 2'd0, 0, 0, 0, 0, 64'h1000, 64'h0, 64'h0, 16'h0004, 0,
           64'h0000_0000_5A00_0000, 64'h1004, 8'h10, 64'h0, 64'h5A, 64'h1004);
    run_op("std R8 pre idx", 2'd3, 1, 0, 1, 0, 64'h8000, 64'h18, 64'hCAFE_F00D_0000_1111, 16'h0, 0,
           64'h0, 64'h8018, 8'hFF, 64'hCAFE_F00D_0000_1111, 64'h0, 64'h8018);
    // R7 invalid loads then recovery
    run_illegal("zero base", 5'd0, 5'd5);
    run_illegal("base eq target", 5'd7, 5'd7);
    run_op("recovery R1", 2'd0, 0, 0, 0, 1, 64'hAB00, 64'h0, 64'h0, 16'h0002, 0,
           64'h3C00_0000_0000_0000, 64'hAB00, 8'h01, 64'h0, 64'h3C, 64'hAB02);

    summary();
  end
endmodule